// File: doc/BRIEF.md
# Ring-to-Idle Transition Sequencer

This block drives the three control bits of a line-card access switch controller (ringing, test-in and test-out). It takes a line out of power ringing and back to the idle/talk state. A level request asks for ringing. When the request drops, the block returns the line to idle in one of two ways, chosen by a mode input sampled at that moment:

- **Make-before-break:** the control bits go straight to the idle code. The ring access switch then opens by itself at its next current zero crossing.
- **Break-before-make:** the block first applies an all-off state. It holds that state for a parameterised number of millisecond ticks, and also until a zero crossing has been observed during the hold. Only then does it apply idle, so the break switches close after the ring access switch has opened.

The parameter `USE_OVR` selects a build-time variant of the all-off hold. In that variant the all-off state is forced through a separate shutdown-override drive, and the control bits already show the idle code. When the hold ends, the override is released.

A busy flag covers the timed hold, and a one-cycle done pulse marks the cycle in which idle is applied. A ring request seen during a hold is remembered and is served once idle has been applied.

Top module: `ring_idle_seq`

## Requirements
- R1: After reset the outputs read ring_o=0, tin_o=0, tout_o=0, ovr_o=0, busy_o=0, done_o=0.
- R2: In idle with ring_req_i=1 at a clock edge, the outputs read ring_o=1, tin_o=0, tout_o=0 after that edge, and stay so while ring_req_i stays 1.
- R3: While ringing, an edge with ring_req_i=0 and mode_bbm_i=0 sets the control bits to 000 and raises done_o for one cycle, without raising busy_o.
- R4: While ringing, an edge with ring_req_i=0 and mode_bbm_i=1 starts the hold. Directly after that edge busy_o=1. With USE_OVR=0 the control bits are ring=1, tin=0, tout=1 (all off) and ovr_o=0.
- R5: With USE_OVR=1 the hold shows control bits 000 and ovr_o=1 (drive the shutdown override low). ovr_o is 0 in every other state.
- R6: The hold ends at the first edge at which both conditions are met: HOLD_MS ticks of ms_tick_i have been counted at edges inside the hold, and a zero crossing has been recorded. After that edge the outputs read 000, ovr_o=0, busy_o=0 and done_o=1.
- R7: zc_seen_i asserted before the hold starts, or at the very edge that starts it, does not count toward ending the hold.
- R8: done_o is high for exactly one cycle per completed transition, and only with the idle code applied.
- R9: ring_req_i=1 at any edge inside a hold is queued. Idle is applied for exactly one cycle, and then ringing starts even if ring_req_i has meanwhile returned to 0.
- R10: Changing mode_bbm_i during a hold does not change the hold's outputs or its length.
- R11: ms_tick_i pulses outside a hold, including the edge that starts it, do not count toward the hold length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_req_i | input | 1 | Level: ringing wanted |
| mode_bbm_i | input | 1 | 1 = break-before-make, 0 = make-before-break |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| zc_seen_i | input | 1 | Ring current zero crossing observed |
| ring_o | output | 1 | Ringing control bit |
| tin_o | output | 1 | Test-in control bit |
| tout_o | output | 1 | Test-out control bit |
| ovr_o | output | 1 | 1 = pull the shutdown override low (USE_OVR variant only) |
| busy_o | output | 1 | All-off hold in progress |
| done_o | output | 1 | One-cycle pulse when idle is applied after ringing |

## Verification
Every output is a function of flops only, so each response appears directly after the clock edge that samples the causing input. For example, the ringing code follows the first edge that sees the request, and the all-off or idle code follows the edge that sees the request drop. The hold ends after the first edge at which both the tick count and the zero-cross record are complete, and the done pulse falls one edge later. The bench drives inputs at falling edges and advances a reference model at rising edges. At every falling edge it compares both build variants against that model. This keeps the sampling half a cycle away from the edge that produces each result, so every result is checked in the cycle it is due.

// File: rtl/r2i_pkg.sv
package r2i_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RING = 2'd1,
      ST_HOLD = 2'd2
   } r2i_state_e;

   typedef struct packed {
      logic ring;
      logic tin;
      logic tout;
   } r2i_ctl_t;

   localparam r2i_ctl_t CTL_IDLE    = '{ring: 1'b0, tin: 1'b0, tout: 1'b0};
   localparam r2i_ctl_t CTL_RINGING = '{ring: 1'b1, tin: 1'b0, tout: 1'b0};
   localparam r2i_ctl_t CTL_ALL_OFF = '{ring: 1'b1, tin: 1'b0, tout: 1'b1};

endpackage

// File: rtl/r2i_hold_timer.sv
module r2i_hold_timer #(
   parameter int HOLD_MS = 25,
   localparam int CNT_W  = $clog2(HOLD_MS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic active_i,
   input  logic ms_tick_i,
   input  logic zc_seen_i,
   output logic expired_o
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(HOLD_MS);

   logic [CNT_W-1:0] cnt_q;
   logic             zc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         zc_q  <= 1'b0;
      end else if (start_i) begin
         cnt_q <= '0;
         zc_q  <= 1'b0;
      end else if (active_i) begin
         if (ms_tick_i && (cnt_q != LIM)) cnt_q <= cnt_q + 1'b1;
         if (zc_seen_i)                   zc_q  <= 1'b1;
      end
   end

   assign expired_o = (cnt_q == LIM) && zc_q;

endmodule

// File: rtl/r2i_fsm.sv
module r2i_fsm
   import r2i_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ring_req_i,
   input  logic       mode_bbm_i,
   input  logic       expired_i,
   output r2i_state_e state_o,
   output logic       start_hold_o,
   output logic       done_o
);
   r2i_state_e state_q, state_d;
   logic       pend_q, pend_d;
   logic       done_q, done_d;

   always_comb begin
      state_d      = state_q;
      pend_d       = pend_q;
      done_d       = 1'b0;
      start_hold_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (pend_q || ring_req_i) begin
               state_d = ST_RING;
               pend_d  = 1'b0;
            end
         end
         ST_RING: begin
            if (!ring_req_i) begin
               if (mode_bbm_i) begin
                  state_d      = ST_HOLD;
                  start_hold_o = 1'b1;
               end else begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end
            end
         end
         ST_HOLD: begin
            pend_d = pend_q | ring_req_i;
            if (expired_i) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         done_q  <= done_d;
      end
   end

   assign state_o = state_q;
   assign done_o  = done_q;

endmodule

// File: rtl/r2i_ctl_decode.sv
module r2i_ctl_decode
   import r2i_pkg::*;
#(
   parameter bit USE_OVR = 1'b0
) (
   input  r2i_state_e state_i,
   output r2i_ctl_t   ctl_o,
   output logic       ovr_o,
   output logic       busy_o
);
   assign busy_o = (state_i == ST_HOLD);

   generate
      if (USE_OVR) begin : g_ovr
         always_comb begin
            ctl_o = (state_i == ST_RING) ? CTL_RINGING : CTL_IDLE;
            ovr_o = (state_i == ST_HOLD);
         end
      end else begin : g_pins
         always_comb begin
            unique case (state_i)
               ST_RING: ctl_o = CTL_RINGING;
               ST_HOLD: ctl_o = CTL_ALL_OFF;
               default: ctl_o = CTL_IDLE;
            endcase
            ovr_o = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/ring_idle_seq.sv
module ring_idle_seq
   import r2i_pkg::*;
#(
   parameter int HOLD_MS = 25,
   parameter bit USE_OVR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ring_req_i,
   input  logic mode_bbm_i,
   input  logic ms_tick_i,
   input  logic zc_seen_i,
   output logic ring_o,
   output logic tin_o,
   output logic tout_o,
   output logic ovr_o,
   output logic busy_o,
   output logic done_o
);
   generate
      if (HOLD_MS < 1) begin : g_bad_hold
         $error("ring_idle_seq: HOLD_MS must be at least 1");
      end
      if (HOLD_MS > 65535) begin : g_big_hold
         $error("ring_idle_seq: HOLD_MS above 65535 is not supported");
      end
   endgenerate

   r2i_state_e state;
   logic       start_hold;
   logic       expired;
   r2i_ctl_t   ctl;

   r2i_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ring_req_i   (ring_req_i),
      .mode_bbm_i   (mode_bbm_i),
      .expired_i    (expired),
      .state_o      (state),
      .start_hold_o (start_hold),
      .done_o       (done_o)
   );

   r2i_hold_timer #(.HOLD_MS(HOLD_MS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_hold),
      .active_i  (state == ST_HOLD),
      .ms_tick_i (ms_tick_i),
      .zc_seen_i (zc_seen_i),
      .expired_o (expired)
   );

   r2i_ctl_decode #(.USE_OVR(USE_OVR)) u_dec (
      .state_i (state),
      .ctl_o   (ctl),
      .ovr_o   (ovr_o),
      .busy_o  (busy_o)
   );

   assign ring_o = ctl.ring;
   assign tin_o  = ctl.tin;
   assign tout_o = ctl.tout;

endmodule

// File: rtl/r2i_checker.sv
module r2i_checker #(
   parameter int HOLD_MS = 25,
   parameter bit USE_OVR = 1'b0,
   localparam int CW     = $clog2(HOLD_MS + 2) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic ms_tick_i,
   input logic ring_o,
   input logic tin_o,
   input logic tout_o,
   input logic ovr_o,
   input logic busy_o,
   input logic done_o
);
   logic [CW-1:0] ticks_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ticks_q <= '0;
      else if (!busy_o)                          ticks_q <= '0;
      else if (ms_tick_i && (ticks_q != '1))     ticks_q <= ticks_q + 1'b1;
   end

   // R8
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!ring_o && !tin_o && !tout_o && !ovr_o && !busy_o));

   // R4
   p_hold_from_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(ring_o) && !$past(tout_o));

   // R4, R5
   p_hold_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (USE_OVR ? (ovr_o && !ring_o && !tin_o && !tout_o)
                          : (!ovr_o && ring_o && !tin_o && tout_o)));

   // R5
   p_ovr_only_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> busy_o);

   // R6
   p_hold_exit_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R6
   p_hold_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (ticks_q >= CW'(HOLD_MS)));

endmodule

bind ring_idle_seq r2i_checker #(.HOLD_MS(HOLD_MS), .USE_OVR(USE_OVR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ms_tick_i (ms_tick_i),
   .ring_o    (ring_o),
   .tin_o     (tin_o),
   .tout_o    (tout_o),
   .ovr_o     (ovr_o),
   .busy_o    (busy_o),
   .done_o    (done_o)
);

// File: tb/tb_ring_idle_seq.sv
`timescale 1ns/1ps
module tb_ring_idle_seq;
   localparam int H = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ring_req = 1'b0, mode_bbm = 1'b0, ms_tick = 1'b0, zc_seen = 1'b0;
   logic a_ring, a_tin, a_tout, a_ovr, a_busy, a_done;
   logic b_ring, b_tin, b_tout, b_ovr, b_busy, b_done;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   string tag  = "R1 reset";

   always #2.5 clk = ~clk;

   ring_idle_seq #(.HOLD_MS(H), .USE_OVR(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .ring_req_i(ring_req), .mode_bbm_i(mode_bbm),
      .ms_tick_i(ms_tick), .zc_seen_i(zc_seen),
      .ring_o(a_ring), .tin_o(a_tin), .tout_o(a_tout), .ovr_o(a_ovr),
      .busy_o(a_busy), .done_o(a_done));

   ring_idle_seq #(.HOLD_MS(H), .USE_OVR(1'b1)) dut_ovr (
      .clk(clk), .rst_n(rst_n), .ring_req_i(ring_req), .mode_bbm_i(mode_bbm),
      .ms_tick_i(ms_tick), .zc_seen_i(zc_seen),
      .ring_o(b_ring), .tin_o(b_tin), .tout_o(b_tout), .ovr_o(b_ovr),
      .busy_o(b_busy), .done_o(b_done));

   // reference model: 0 idle, 1 ringing, 2 hold
   int m_st = 0, m_cnt = 0;
   bit m_zc = 0, m_pend = 0, m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_zc = 0; m_pend = 0; m_done = 0;
      end else begin
         m_done = 0;
         case (m_st)
            0: if (m_pend || ring_req) begin m_st = 1; m_pend = 0; end
            1: if (!ring_req) begin
                  if (mode_bbm) begin m_st = 2; m_cnt = 0; m_zc = 0; end
                  else begin m_st = 0; m_done = 1; end
               end
            default: begin
               m_pend = m_pend | ring_req;
               if (m_cnt == H && m_zc) begin m_st = 0; m_done = 1; end
               else begin
                  if (ms_tick && m_cnt < H) m_cnt++;
                  if (zc_seen) m_zc = 1;
               end
            end
         endcase
      end
   end

   // {ring, tin, tout, ovr, busy, done}
   function automatic logic [5:0] exp_vec(int st, bit dn, bit use_ovr);
      case (st)
         1:       return 6'b100000;
         2:       return use_ovr ? 6'b000110 : 6'b101010;
         default: return {5'b00000, dn};
      endcase
   endfunction

   always @(negedge clk) begin
      logic [5:0] ea, eb, va, vb;
      ea = exp_vec(m_st, m_done, 1'b0);
      eb = exp_vec(m_st, m_done, 1'b1);
      va = {a_ring, a_tin, a_tout, a_ovr, a_busy, a_done};
      vb = {b_ring, b_tin, b_tout, b_ovr, b_busy, b_done};
      n_tests += 2;
      if (va !== ea) begin
         n_fail++;
         $display("FAIL %s pins-variant act=%b exp=%b t=%0t", tag, va, ea, $time);
      end
      if (vb !== eb) begin
         n_fail++;
         $display("FAIL %s override-variant act=%b exp=%b t=%0t", tag, vb, eb, $time);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         ms_tick = 1'b1; cyc(1);
         ms_tick = 1'b0; cyc(1);
      end
   endtask

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      tag = "R1 reset";
      cyc(4);
      rst_n = 1'b1;
      cyc(2);

      tag = "R2 ringing code";
      ring_req = 1'b1; cyc(5);
      tag = "R3 make-before-break";
      mode_bbm = 1'b0; ring_req = 1'b0; cyc(5);

      tag = "R7 early zero cross";
      ring_req = 1'b1; cyc(3);
      zc_seen = 1'b1; cyc(2);
      tag = "R4 hold entry";
      mode_bbm = 1'b1; ring_req = 1'b0; cyc(1);
      zc_seen = 1'b0;
      tag = "R6 hold length";
      ticks(H + 3);
      tag = "R10 mode change in hold";
      mode_bbm = 1'b0; cyc(6);
      tag = "R6 hold exit";
      zc_seen = 1'b1; cyc(1); zc_seen = 1'b0; cyc(5);

      tag = "R11 ticks outside hold";
      ticks(H + 5);
      ring_req = 1'b1; cyc(3);
      mode_bbm = 1'b1; ms_tick = 1'b1; ring_req = 1'b0; cyc(1);
      ms_tick = 1'b0; zc_seen = 1'b1; cyc(1); zc_seen = 1'b0;
      ticks(H - 1);
      cyc(4);
      tag = "R5 override hold exit";
      ticks(2); cyc(4);

      tag = "R9 queued request";
      ring_req = 1'b1; cyc(3);
      ring_req = 1'b0; cyc(2);
      ring_req = 1'b1; cyc(1); ring_req = 1'b0;
      zc_seen = 1'b1; cyc(1); zc_seen = 1'b0;
      ticks(H + 1);
      mode_bbm = 1'b0; cyc(8);
      tag = "R8 done pulse";
      cyc(3);

      tag = "R6 random mix";
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 19) == 0) ring_req = ~ring_req;
         if ($urandom_range(0, 29) == 0) mode_bbm = ~mode_bbm;
         ms_tick = ($urandom_range(0, 2) == 0);
         zc_seen = ($urandom_range(0, 14) == 0);
         cyc(1);
      end
      ring_req = 1'b0; ms_tick = 1'b0; zc_seen = 1'b0;
      cyc(4);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule